// File: doc/BRIEF.md
# Serial Code-Memory Programming Slave

This block lets an external host load and verify a byte-wide on-chip code memory over a four-wire serial link. The host holds the programming-mode level high, clocks 32-bit instruction frames in on MOSI with SCK, and reads returned bytes on MISO. The block oversamples SCK, MOSI and the mode level on its own system clock. It works out the command at the end of each frame and acts on the memory array, which is built into the block.

A session starts with an unlock instruction. Until the unlock is accepted, every other instruction is dropped. An erase fills the whole array with 0xFF. A byte write stores one byte, but only into a location that still reads 0xFF; a write to any other location is refused and raises a sticky error flag. An accepted write starts a self-timed write cycle. While that cycle runs, a read of the pending address returns the byte being written with its top bit flipped, so the host can poll for completion. Dropping the mode level ends the session at once.

Top module: `isp_prog_slave`

## Requirements
- R1: Before an unlock frame (byte 1 = 0xAC, byte 2 = 0x53) is accepted, erase, write and read frames have no effect: the memory is unchanged, busy stays low, err stays low and a read returns 0x00.
- R2: Driving prog_rst low clears the unlocked state and discards any partly received frame, so that the next frame after prog_rst returns high is aligned from its first bit.
- R3: An unlocked erase frame (byte 1 = 0xAC, byte 2 = 0x80) sent while no write cycle runs sets every memory location to 0xFF. After system reset every location holds 0x00.
- R4: An unlocked write frame (byte 1 = 0x40) to a location holding 0xFF raises busy for exactly WR_CYCLES system clocks. The data byte is stored when busy falls.
- R5: A write frame to a location that does not hold 0xFF leaves the memory unchanged, keeps busy low and sets err. The err output stays set until prog_rst goes low.
- R6: An unlocked read frame (byte 1 = 0x20) returns the addressed byte on MISO during byte 4, MSB first. Each bit is valid before the SCK rising edge that samples it. The 13-bit address is bits 4..0 of byte 2 followed by byte 3, and only its low ADDR_W bits select the location.
- R7: While busy is high, a read of the pending address returns the pending data with bit 7 inverted. A read of any other address returns the stored byte.
- R8: While busy is high, write and erase frames are ignored. They change neither the pending write nor the memory.
- R9: A frame is 32 bits, sent MSB first and sampled on rising SCK, and bits are taken only while prog_rst is high. MISO is low while prog_rst is low. SCK's high and low times must each be at least 8 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low system reset |
| prog_rst | input | 1 | Programming-mode level, active high |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a self-timed write cycle runs |
| err | output | 1 | Sticky flag for a refused write |

## Verification
A wrong unlock or pending-write state shows up at the ports within one frame. It appears as a read byte that differs from the model, as a busy pulse where none belongs, or as a change in err right after a frame. A wrong bit count shows up as a misaligned read byte in the first frame that follows. A bad write-cycle counter shows up as a busy pulse of the wrong length, or as a polled byte that changes at the wrong moment. The bench measures the busy length and polls the pending address while the write cycle is still running, so these faults are caught while the cycle is in progress.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_CTRL    = 8'hAC;
  localparam logic [7:0] SUB_UNLOCK = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] OP_WRITE   = 8'h40;
  localparam logic [7:0] OP_READ    = 8'h20;
  localparam logic [7:0] BLANK      = 8'hFF;
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 24;
  localparam int ADDR_FIELD = 13;

  // Polled value of a byte still being written
  function automatic logic [7:0] poll_byte(input logic [7:0] d);
    return d ^ 8'h80;
  endfunction

  // Address field from a 24-bit header (opcode, addr-hi, addr-lo)
  function automatic logic [ADDR_FIELD-1:0] addr_field(input logic [HDR_BITS-1:0] hdr);
    return hdr[ADDR_FIELD-1:0];
  endfunction
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_raw,
  input  logic mosi_raw,
  input  logic sck_raw,
  output logic prog_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic [2:0] pipe [STAGES];
  logic       sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      sck_prev <= 1'b0;
    end else begin
      pipe[0] <= {prog_raw, mosi_raw, sck_raw};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_prev <= pipe[STAGES-1][0];
    end
  end

  assign prog_s   = pipe[STAGES-1][2];
  assign mosi_s   = pipe[STAGES-1][1];
  assign sck_rise = pipe[STAGES-1][0] & ~sck_prev;
  assign sck_fall = ~pipe[STAGES-1][0] & sck_prev;
endmodule

// File: rtl/isp_frame_rx.sv
module isp_frame_rx #(
  parameter int FRAME_BITS = 32,
  parameter int HDR_BITS   = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_s,
  input  logic                  mosi_s,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic [7:0]            tx_byte,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  frame_done,
  output logic                  hdr_done,
  output logic                  miso
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] HDR_CNT  = CW'(HDR_BITS);

  logic [CW-1:0] bit_cnt;
  logic [7:0]    tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      frame      <= '0;
      tx_sr      <= '0;
      frame_done <= 1'b0;
      hdr_done   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      hdr_done   <= 1'b0;
      if (!prog_s) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
      end else begin
        if (sck_rise) begin
          frame <= {frame[FRAME_BITS-2:0], mosi_s};
          if (bit_cnt == LAST_BIT) begin
            bit_cnt    <= '0;
            frame_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (bit_cnt == HDR_LAST) hdr_done <= 1'b1;
        end
        if (hdr_done)
          tx_sr <= tx_byte;
        else if (sck_fall && bit_cnt > HDR_CNT)
          tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign miso = prog_s & tx_sr[7];

  // R2: leaving programming mode discards the partial frame
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_s |=> (bit_cnt == '0));
endmodule

// File: rtl/isp_code_mem.sv
module isp_code_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] caddr,
  output logic [DATA_W-1:0] cdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign cdata = mem[caddr];
endmodule

// File: rtl/isp_prog_slave.sv
module isp_prog_slave
  import isp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WR_CYCLES   = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy,
  output logic err
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);

  logic prog_s, mosi_s, sck_rise, sck_fall;
  logic [FRAME_BITS-1:0] frame;
  logic frame_done, hdr_done;
  logic [7:0] tx_byte;

  isp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .prog_raw(prog_rst), .mosi_raw(mosi), .sck_raw(sck),
    .prog_s(prog_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall));

  isp_frame_rx #(.FRAME_BITS(FRAME_BITS), .HDR_BITS(HDR_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .prog_s(prog_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .tx_byte(tx_byte),
    .frame(frame), .frame_done(frame_done), .hdr_done(hdr_done), .miso(miso));

  // Field views of a complete frame and of a received header
  logic [7:0] cmd_op, cmd_sub, cmd_data, hdr_op;
  logic [ADDR_FIELD-1:0] cmd_addr_f, hdr_addr_f;
  logic [ADDR_W-1:0] cmd_addr, hdr_addr;
  assign cmd_op     = frame[31:24];
  assign cmd_sub    = frame[23:16];
  assign cmd_data   = frame[7:0];
  assign cmd_addr_f = addr_field(frame[31:8]);
  assign cmd_addr   = cmd_addr_f[ADDR_W-1:0];
  assign hdr_op     = frame[23:16];
  assign hdr_addr_f = addr_field(frame[23:0]);
  assign hdr_addr   = hdr_addr_f[ADDR_W-1:0];

  logic en_q, err_q;
  logic [CNT_W-1:0] wr_cnt;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0] pend_data;
  logic [7:0] rd_data, chk_data;

  // Named command events
  logic unlock_go, erase_go, wr_try, wr_accept, wr_reject, mem_we;
  assign unlock_go = frame_done && cmd_op == OP_CTRL && cmd_sub == SUB_UNLOCK;
  assign erase_go  = frame_done && en_q && !busy && cmd_op == OP_CTRL && cmd_sub == SUB_ERASE;
  assign wr_try    = frame_done && en_q && !busy && cmd_op == OP_WRITE;
  assign wr_accept = wr_try && chk_data == BLANK;
  assign wr_reject = wr_try && chk_data != BLANK;
  assign mem_we    = wr_cnt == CNT_W'(1);
  assign busy      = wr_cnt != '0;
  assign err       = err_q;

  isp_code_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .erase(erase_go), .we(mem_we),
    .waddr(pend_addr), .wdata(pend_data),
    .raddr(hdr_addr), .rdata(rd_data),
    .caddr(cmd_addr), .cdata(chk_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      err_q     <= 1'b0;
      wr_cnt    <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      if (!prog_s) begin
        en_q  <= 1'b0;
        err_q <= 1'b0;
      end else begin
        if (unlock_go) en_q <= 1'b1;
        if (wr_reject) err_q <= 1'b1;
      end
      if (wr_accept) begin
        wr_cnt    <= CNT_LOAD;
        pend_addr <= cmd_addr;
        pend_data <= cmd_data;
      end else if (busy) begin
        wr_cnt <= wr_cnt - 1'b1;
      end
    end
  end

  // Byte returned in the fourth frame byte
  always_comb begin
    tx_byte = 8'h00;
    if (en_q && hdr_op == OP_READ)
      tx_byte = (busy && hdr_addr == pend_addr) ? poll_byte(pend_data) : rd_data;
  end

  // R4: a write cycle only starts from a completed frame
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_done));
  // R4: the memory is written in the last busy cycle
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_we));
  // R5: err is raised only by a frame received while unlocked
  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(frame_done && en_q));
  // R1: a frame received while locked starts nothing
  p_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !en_q) |=> (!$rose(busy) && !$rose(err)));
  // R8: a frame during a write cycle leaves the pending write alone
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_done) |=> ($stable(pend_addr) && $stable(pend_data)));
endmodule

// File: tb/isp_prog_slave_tb_top.sv
module isp_prog_slave_tb_top;
  localparam int WR_CYCLES = 4000;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, prog_rst = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy, err;
  always #10 clk = ~clk;

  isp_prog_slave #(.ADDR_W(8), .WR_CYCLES(WR_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy), .err(err));

  int tests = 0, fails = 0, busy_cycles = 0;
  bit finished = 1'b0;

  // Behavioural reference model
  int ref_mem [256];
  bit ref_en = 0, ref_err = 0, ref_busy = 0;
  int ref_paddr = 0, ref_pdata = 0;

  always @(negedge clk) if (busy === 1'b1) busy_cycles++;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] f, output logic [7:0] rb);
    rb = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      mosi = f[i];
      repeat (HALF) @(negedge clk);
      if (i < 8) rb[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd(input string req, input logic [7:0] b1, input logic [7:0] b2,
                     input logic [12:0] a, input logic [7:0] b4);
    logic [7:0] rb;
    int exp_rd, idx;
    logic [31:0] f;
    idx = int'(a[7:0]);
    if (b1 == 8'h20 || b1 == 8'h40) f = {b1, 3'b000, a[12:8], a[7:0], b4};
    else f = {b1, b2, a[7:0], b4};
    exp_rd = 0;
    if (ref_en && b1 == 8'h20)
      exp_rd = (ref_busy && idx == ref_paddr) ? (ref_pdata ^ 8'h80) : ref_mem[idx];
    xfer(f, rb);
    if (b1 == 8'h20) check({req, " read byte"}, int'(rb), exp_rd);
    if (ref_en && !ref_busy) begin
      if (b1 == 8'hAC && b2 == 8'h80) for (int k = 0; k < 256; k++) ref_mem[k] = 8'hFF;
      if (b1 == 8'h40) begin
        if (ref_mem[idx] == 8'hFF) begin
          ref_busy = 1; ref_paddr = idx; ref_pdata = int'(b4);
        end else ref_err = 1;
      end
    end
    if (b1 == 8'hAC && b2 == 8'h53) ref_en = 1;
    check({req, " err"}, int'(err), int'(ref_err));
  endtask

  task automatic wait_commit(input string req);
    int guard = 0;
    while (busy === 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    check({req, " busy length"}, busy_cycles, WR_CYCLES);
    if (ref_busy) begin ref_mem[ref_paddr] = ref_pdata; ref_busy = 0; end
  endtask

  task automatic leave_mode(input string req);
    prog_rst = 1'b0;
    repeat (10) @(negedge clk);
    ref_en = 0; ref_err = 0;
    check({req, " err cleared"}, int'(err), 0);
    check("R9 miso low out of mode", int'(miso), 0);
    prog_rst = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) ref_mem[k] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 reset miso", int'(miso), 0);
    check("R4 reset busy", int'(busy), 0);
    check("R5 reset err", int'(err), 0);
    prog_rst = 1'b1;
    repeat (10) @(negedge clk);

    // R1: locked, nothing takes effect
    busy_cycles = 0;
    cmd("R1 locked erase", 8'hAC, 8'h80, 13'h000, 8'h00);
    cmd("R1 locked write", 8'h40, 8'h00, 13'h010, 8'h12);
    cmd("R1 locked read", 8'h20, 8'h00, 13'h010, 8'h00);
    check("R1 no busy while locked", busy_cycles, 0);

    // R2 unlock, R5 write to a non-blank location refused
    cmd("R2 unlock", 8'hAC, 8'h53, 13'h000, 8'h00);
    cmd("R1 erase skipped before unlock", 8'h20, 8'h00, 13'h020, 8'h00);
    busy_cycles = 0;
    cmd("R5 write to 00 refused", 8'h40, 8'h00, 13'h010, 8'h12);
    check("R5 no busy on refusal", busy_cycles, 0);
    cmd("R5 memory unchanged", 8'h20, 8'h00, 13'h010, 8'h00);
    leave_mode("R5");

    // R3 erase
    cmd("R2 unlock again", 8'hAC, 8'h53, 13'h000, 8'h00);
    cmd("R3 erase", 8'hAC, 8'h80, 13'h000, 8'h00);
    cmd("R3 erased low", 8'h20, 8'h00, 13'h010, 8'h00);
    cmd("R3 erased top", 8'h20, 8'h00, 13'h0FF, 8'h00);

    // R4 write, R7 polling, R8 ignored commands while busy
    busy_cycles = 0;
    cmd("R4 write", 8'h40, 8'h00, 13'h010, 8'h5A);
    check("R4 busy high after write", int'(busy), 1);
    cmd("R7 poll pending", 8'h20, 8'h00, 13'h010, 8'h00);
    cmd("R8 write while busy", 8'h40, 8'h00, 13'h011, 8'h33);
    cmd("R8 erase while busy", 8'hAC, 8'h80, 13'h000, 8'h00);
    cmd("R7 other address", 8'h20, 8'h00, 13'h011, 8'h00);
    wait_commit("R4");
    cmd("R4 stored value", 8'h20, 8'h00, 13'h010, 8'h00);
    cmd("R8 dropped write", 8'h20, 8'h00, 13'h011, 8'h00);

    // R6 address aliasing and MSB-first data on another pattern
    busy_cycles = 0;
    cmd("R4 second write", 8'h40, 8'h00, 13'h0C3, 8'hA5);
    wait_commit("R4 second");
    cmd("R6 read alias", 8'h20, 8'h00, 13'h1110, 8'h00);
    cmd("R6 read pattern", 8'h20, 8'h00, 13'h00C3, 8'h00);
    cmd("R5 rewrite refused", 8'h40, 8'h00, 13'h010, 8'h00);

    // R2: leaving mode clears unlock and drops a partial frame
    leave_mode("R5 second");
    cmd("R2 locked after exit", 8'h20, 8'h00, 13'h010, 8'h00);
    cmd("R2 unlock", 8'hAC, 8'h53, 13'h000, 8'h00);
    for (int i = 0; i < 10; i++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    leave_mode("R2 abort");
    cmd("R2 unlock after abort", 8'hAC, 8'h53, 13'h000, 8'h00);
    cmd("R2 aligned read", 8'h20, 8'h00, 13'h010, 8'h00);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule